// File: doc/BRIEF.md
# Oldest Exception Tracker

This block keeps a single record: the oldest exception still pending in a reorder buffer. Faults that front-end or decode logic raises arrive on a set of in-order enqueue ports. Faults from execution units arrive on a set of writeback ports, in any order. Anything younger than a faulting instruction will be thrown away, so the block does not need to keep more than one record.

Selection happens in two register stages. The first stage handles two kinds of input. On the enqueue side, the lowest-numbered valid port wins. On the writeback side, the ports are split into fixed groups and each group picks its oldest candidate by age. The second stage compares the group winners with the enqueue winner, and then merges the result into the held record.

Each record carries three things: a wrap-flagged reorder index, an exception vector, and a vector start position. When two records have the same index, the one with the smaller start position is kept. Commit logic reads the held record. Commit logic empties the record with a clear input once the exception has been taken. A redirect removes every record that the redirect squashes.

Top module: `oldest_exc_tracker`

## Requirements
- R1: After reset, `hold_valid` is 0.
- R2: Among the enqueue ports valid in one cycle, only the lowest-numbered port is a candidate, even if a higher port carries an older index.
- R3: An index is `{flag, value}`, with the flag as the MSB. If two indices have the same flag, the smaller value is older. If the flags differ, the larger value is older. Among the writeback ports, the oldest candidate is chosen.
- R4: A candidate driven in the cycle before clock edge k is visible on the `hold_*` outputs after edge k+1. After edge k alone, it is not yet visible.
- R5: A candidate replaces the held record only if it is older than the held record, or if the held record is empty. A younger candidate leaves all `hold_*` outputs unchanged.
- R6: If a candidate has the same index as the held record, it replaces the held record only when its vector start is strictly smaller.
- R7: `clear` empties the held record at the next edge. A candidate already in the first stage during that cycle is still merged, so it becomes the new record even if it is younger than the record that was cleared.
- R8: A redirect (`redir_valid`) removes the held record if the record is younger than `redir_ptr`, or equal to it when `redir_self` is 1. Otherwise the held record is kept.
- R9: The same redirect rule discards candidates that are on the inputs or in the first stage during the redirect cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | ENQ_N | Enqueue port carries an exception |
| enq_ptr | input | ENQ_N x (IDX_W+1) | Enqueue reorder index, flag in MSB |
| enq_exc | input | ENQ_N x EXC_W | Enqueue exception vector |
| enq_vstart | input | ENQ_N x VS_W | Enqueue vector start |
| wb_valid | input | WB_N | Writeback port carries an exception |
| wb_ptr | input | WB_N x (IDX_W+1) | Writeback reorder index |
| wb_exc | input | WB_N x EXC_W | Writeback exception vector |
| wb_vstart | input | WB_N x VS_W | Writeback vector start |
| redir_valid | input | 1 | Redirect this cycle |
| redir_ptr | input | IDX_W+1 | Redirect index |
| redir_self | input | 1 | Redirect also squashes its own index |
| clear | input | 1 | Held exception has been taken |
| hold_valid | output | 1 | Held record is valid |
| hold_ptr | output | IDX_W+1 | Held reorder index |
| hold_exc | output | EXC_W | Held exception vector |
| hold_vstart | output | VS_W | Held vector start |

## Verification
A faulty age comparison or tie-break shows up within two cycles as the wrong index or vector start on `hold_ptr` or `hold_vstart`. A faulty redirect or clear filter shows up within two cycles as a stale record, or as a missing one. A reference list of all pending exceptions predicts the minimum after every stimulus. Directed sequences target the first stage specifically, because a lost or leaked first-stage candidate only becomes visible one edge later.

// File: rtl/exc_trk_pkg.sv
package exc_trk_pkg;

   // True when index a is strictly older than index b (pw bits, flag in MSB).
   function automatic logic ptr_older(input logic [31:0] a, input logic [31:0] b,
                                      input int unsigned pw);
      logic [31:0] msk;
      logic        flip;
      msk  = (32'd1 << (pw - 1)) - 32'd1;
      flip = a[pw-1] ^ b[pw-1];
      return flip ? ((a & msk) > (b & msk)) : ((a & msk) < (b & msk));
   endfunction

   // Candidate a beats b: older, or same index with smaller vector start.
   function automatic logic cand_better(input logic [31:0] ap, input logic [31:0] avs,
                                        input logic [31:0] bp, input logic [31:0] bvs,
                                        input int unsigned pw);
      return ptr_older(ap, bp, pw) || ((ap == bp) && (avs < bvs));
   endfunction

   // Candidate c is squashed by a redirect at r.
   function automatic logic squashed(input logic [31:0] c, input logic [31:0] r,
                                     input logic self_f, input int unsigned pw);
      return ptr_older(r, c, pw) || ((c == r) && self_f);
   endfunction

endpackage

// File: rtl/exc_select.sv
module exc_select #(
   parameter int unsigned N       = 3,
   parameter int unsigned PW      = 9,
   parameter int unsigned EW      = 16,
   parameter int unsigned VW      = 8,
   parameter bit          ORDERED = 1'b0
) (
   input  logic [N-1:0]         c_v,
   input  logic [N-1:0][PW-1:0] c_ptr,
   input  logic [N-1:0][EW-1:0] c_exc,
   input  logic [N-1:0][VW-1:0] c_vs,
   output logic                 o_v,
   output logic [PW-1:0]        o_ptr,
   output logic [EW-1:0]        o_exc,
   output logic [VW-1:0]        o_vs
);

   logic          b_v;
   logic [PW-1:0] b_ptr;
   logic [EW-1:0] b_exc;
   logic [VW-1:0] b_vs;

   generate
      if (ORDERED) begin : g_prio
         // Ports are in program order: the lowest valid port wins.
         always_comb begin
            b_v   = 1'b0;
            b_ptr = '0;
            b_exc = '0;
            b_vs  = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (c_v[i]) begin
                  b_v   = 1'b1;
                  b_ptr = c_ptr[i];
                  b_exc = c_exc[i];
                  b_vs  = c_vs[i];
               end
            end
         end
      end else begin : g_age
         // Out-of-order ports: keep the strictly better candidate, ties stay low.
         always_comb begin
            b_v   = 1'b0;
            b_ptr = '0;
            b_exc = '0;
            b_vs  = '0;
            for (int i = 0; i < N; i++) begin
               if (c_v[i] && (!b_v || exc_trk_pkg::cand_better(32'(c_ptr[i]), 32'(c_vs[i]),
                                                               32'(b_ptr), 32'(b_vs), PW))) begin
                  b_v   = 1'b1;
                  b_ptr = c_ptr[i];
                  b_exc = c_exc[i];
                  b_vs  = c_vs[i];
               end
            end
         end
      end
   endgenerate

   assign o_v   = b_v;
   assign o_ptr = b_ptr;
   assign o_exc = b_exc;
   assign o_vs  = b_vs;

endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg #(
   parameter int unsigned PW = 9,
   parameter int unsigned EW = 16,
   parameter int unsigned VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [PW-1:0] in_ptr,
   input  logic [EW-1:0] in_exc,
   input  logic [VW-1:0] in_vs,
   input  logic          redir_valid,
   input  logic [PW-1:0] redir_ptr,
   input  logic          redir_self,
   output logic          out_v,
   output logic [PW-1:0] out_ptr,
   output logic [EW-1:0] out_exc,
   output logic [VW-1:0] out_vs
);

   logic kill_in;
   assign kill_in = redir_valid &&
                    exc_trk_pkg::squashed(32'(in_ptr), 32'(redir_ptr), redir_self, PW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v   <= 1'b0;
         out_ptr <= '0;
         out_exc <= '0;
         out_vs  <= '0;
      end else begin
         out_v   <= in_v && !kill_in;
         out_ptr <= in_ptr;
         out_exc <= in_exc;
         out_vs  <= in_vs;
      end
   end

   // A redirect leaves nothing younger than itself in this stage.
   assert_stage_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> (!out_v || !exc_trk_pkg::squashed(32'(out_ptr), 32'($past(redir_ptr)),
                                                         $past(redir_self), PW)));

endmodule

// File: rtl/oldest_exc_tracker.sv
module oldest_exc_tracker #(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned EXC_W  = 16,
   parameter int unsigned VS_W   = 8,
   parameter int unsigned ENQ_N  = 6,
   parameter int unsigned WB_N   = 6,
   parameter int unsigned GRP_SZ = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ENQ_N-1:0]               enq_valid,
   input  logic [ENQ_N-1:0][IDX_W:0]      enq_ptr,
   input  logic [ENQ_N-1:0][EXC_W-1:0]    enq_exc,
   input  logic [ENQ_N-1:0][VS_W-1:0]     enq_vstart,
   input  logic [WB_N-1:0]                wb_valid,
   input  logic [WB_N-1:0][IDX_W:0]       wb_ptr,
   input  logic [WB_N-1:0][EXC_W-1:0]     wb_exc,
   input  logic [WB_N-1:0][VS_W-1:0]      wb_vstart,
   input  logic                           redir_valid,
   input  logic [IDX_W:0]                 redir_ptr,
   input  logic                           redir_self,
   input  logic                           clear,
   output logic                           hold_valid,
   output logic [IDX_W:0]                 hold_ptr,
   output logic [EXC_W-1:0]               hold_exc,
   output logic [VS_W-1:0]                hold_vstart
);

   localparam int unsigned PW    = IDX_W + 1;
   localparam int unsigned NGRP  = WB_N / GRP_SZ;
   localparam int unsigned NCAND = NGRP + 1;

   generate
      if (WB_N % GRP_SZ != 0) begin : g_bad_group
         $error("WB_N must be a multiple of GRP_SZ");
      end
      if (PW > 32) begin : g_bad_width
         $error("IDX_W must be below 32");
      end
   endgenerate

   // First-stage results: one slot per writeback group plus the enqueue slot.
   logic [NCAND-1:0]            s1_v;
   logic [NCAND-1:0][PW-1:0]    s1_ptr;
   logic [NCAND-1:0][EXC_W-1:0] s1_exc;
   logic [NCAND-1:0][VS_W-1:0]  s1_vs;

   genvar g;
   generate
      for (g = 0; g < NGRP; g++) begin : g_grp
         logic             gv;
         logic [PW-1:0]    gp;
         logic [EXC_W-1:0] ge;
         logic [VS_W-1:0]  gs;

         exc_select #(.N(GRP_SZ), .PW(PW), .EW(EXC_W), .VW(VS_W), .ORDERED(1'b0)) u_pick (
            .c_v  (wb_valid [g*GRP_SZ +: GRP_SZ]),
            .c_ptr(wb_ptr   [g*GRP_SZ +: GRP_SZ]),
            .c_exc(wb_exc   [g*GRP_SZ +: GRP_SZ]),
            .c_vs (wb_vstart[g*GRP_SZ +: GRP_SZ]),
            .o_v(gv), .o_ptr(gp), .o_exc(ge), .o_vs(gs));

         exc_stage_reg #(.PW(PW), .EW(EXC_W), .VW(VS_W)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .in_v(gv), .in_ptr(gp), .in_exc(ge), .in_vs(gs),
            .redir_valid(redir_valid), .redir_ptr(redir_ptr), .redir_self(redir_self),
            .out_v(s1_v[g]), .out_ptr(s1_ptr[g]), .out_exc(s1_exc[g]), .out_vs(s1_vs[g]));
      end
   endgenerate

   logic             eq_v;
   logic [PW-1:0]    eq_p;
   logic [EXC_W-1:0] eq_e;
   logic [VS_W-1:0]  eq_s;

   exc_select #(.N(ENQ_N), .PW(PW), .EW(EXC_W), .VW(VS_W), .ORDERED(1'b1)) u_enq_pick (
      .c_v(enq_valid), .c_ptr(enq_ptr), .c_exc(enq_exc), .c_vs(enq_vstart),
      .o_v(eq_v), .o_ptr(eq_p), .o_exc(eq_e), .o_vs(eq_s));

   exc_stage_reg #(.PW(PW), .EW(EXC_W), .VW(VS_W)) u_enq_stage (
      .clk(clk), .rst_n(rst_n),
      .in_v(eq_v), .in_ptr(eq_p), .in_exc(eq_e), .in_vs(eq_s),
      .redir_valid(redir_valid), .redir_ptr(redir_ptr), .redir_self(redir_self),
      .out_v(s1_v[NGRP]), .out_ptr(s1_ptr[NGRP]), .out_exc(s1_exc[NGRP]), .out_vs(s1_vs[NGRP]));

   // Second stage: drop squashed slots, then pick the oldest slot.
   logic [NCAND-1:0] s1_live;
   always_comb begin
      for (int i = 0; i < NCAND; i++) begin
         s1_live[i] = s1_v[i] && !(redir_valid &&
                      exc_trk_pkg::squashed(32'(s1_ptr[i]), 32'(redir_ptr), redir_self, PW));
      end
   end

   logic             win_v;
   logic [PW-1:0]    win_ptr;
   logic [EXC_W-1:0] win_exc;
   logic [VS_W-1:0]  win_vs;

   exc_select #(.N(NCAND), .PW(PW), .EW(EXC_W), .VW(VS_W), .ORDERED(1'b0)) u_final_pick (
      .c_v(s1_live), .c_ptr(s1_ptr), .c_exc(s1_exc), .c_vs(s1_vs),
      .o_v(win_v), .o_ptr(win_ptr), .o_exc(win_exc), .o_vs(win_vs));

   // Held record merge.
   logic hold_keep, take_win;
   assign hold_keep = hold_valid && !clear &&
                      !(redir_valid && exc_trk_pkg::squashed(32'(hold_ptr), 32'(redir_ptr),
                                                             redir_self, PW));
   assign take_win  = win_v && (!hold_keep ||
                      exc_trk_pkg::cand_better(32'(win_ptr), 32'(win_vs),
                                               32'(hold_ptr), 32'(hold_vstart), PW));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_valid  <= 1'b0;
         hold_ptr    <= '0;
         hold_exc    <= '0;
         hold_vstart <= '0;
      end else if (take_win) begin
         hold_valid  <= 1'b1;
         hold_ptr    <= win_ptr;
         hold_exc    <= win_exc;
         hold_vstart <= win_vs;
      end else begin
         hold_valid  <= hold_keep;
      end
   end

   // Held record never turns younger while nothing removes it.
   assert_never_younger_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid && !clear && !redir_valid) |=>
      (hold_valid && !exc_trk_pkg::ptr_older(32'($past(hold_ptr)), 32'(hold_ptr), PW)));

   // Same index keeps a non-increasing vector start.
   assert_tie_vstart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid && !clear && !redir_valid) |=>
      ((hold_ptr != $past(hold_ptr)) || (hold_vstart <= $past(hold_vstart))));

   // Clear with no second-stage winner leaves the record empty.
   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !win_v) |=> !hold_valid);

   // After a redirect, the record is not squashed by it.
   assert_redirect_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> (!hold_valid || !exc_trk_pkg::squashed(32'(hold_ptr),
                       32'($past(redir_ptr)), $past(redir_self), PW)));

   // Empty record and empty pipeline stay empty for one more edge.
   assert_no_early_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_valid && !win_v) |=> !hold_valid);

endmodule

// File: tb/oldest_exc_tracker_tb_top.sv
module oldest_exc_tracker_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NE = 6;
   localparam int NW = 6;

   typedef struct packed {
      logic [3:0] req;
      logic [2:0] wport; logic wv; logic [8:0] wptr; logic [7:0] wvs;
      logic [2:0] eport; logic ev; logic [8:0] eptr;
      logic clr; logic rv; logic [8:0] rptr; logic rs;
   } vec_t;

   // Rows: R3 pick, R5 younger ignored, R3 wrap, R6 tie, R7 clear, R8 redirect, R2 enqueue, R9 input kill.
   localparam vec_t VECS [15] = '{
      '{4'd3, 3'd0, 1'b1, 9'h020, 8'd0, 3'd0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0,   1'b0},
      '{4'd5, 3'd3, 1'b1, 9'h030, 8'd0, 3'd0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0,   1'b0},
      '{4'd3, 3'd5, 1'b1, 9'h010, 8'd9, 3'd0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0,   1'b0},
      '{4'd3, 3'd1, 1'b1, 9'h105, 8'd0, 3'd0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0,   1'b0},
      '{4'd6, 3'd2, 1'b1, 9'h010, 8'd4, 3'd0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0,   1'b0},
      '{4'd6, 3'd4, 1'b1, 9'h010, 8'd7, 3'd0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0,   1'b0},
      '{4'd7, 3'd0, 1'b0, 9'h000, 8'd0, 3'd0, 1'b0, 9'h0, 1'b1, 1'b0, 9'h0,   1'b0},
      '{4'd3, 3'd4, 1'b1, 9'h1F0, 8'd0, 3'd0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0,   1'b0},
      '{4'd3, 3'd0, 1'b1, 9'h0F8, 8'd0, 3'd0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0,   1'b0},
      '{4'd8, 3'd0, 1'b0, 9'h000, 8'd0, 3'd0, 1'b0, 9'h0, 1'b0, 1'b1, 9'h0F8, 1'b0},
      '{4'd8, 3'd0, 1'b0, 9'h000, 8'd0, 3'd0, 1'b0, 9'h0, 1'b0, 1'b1, 9'h0F8, 1'b1},
      '{4'd2, 3'd0, 1'b0, 9'h000, 8'd0, 3'd2, 1'b1, 9'h040, 1'b0, 1'b0, 9'h0, 1'b0},
      '{4'd9, 3'd1, 1'b1, 9'h050, 8'd0, 3'd0, 1'b0, 9'h0, 1'b0, 1'b1, 9'h045, 1'b0},
      '{4'd2, 3'd0, 1'b0, 9'h000, 8'd0, 3'd1, 1'b1, 9'h030, 1'b0, 1'b0, 9'h0, 1'b0},
      '{4'd7, 3'd0, 1'b0, 9'h000, 8'd0, 3'd0, 1'b0, 9'h0, 1'b1, 1'b0, 9'h0,   1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NE-1:0]        enq_valid = '0;
   logic [NE-1:0][8:0]   enq_ptr = '0;
   logic [NE-1:0][15:0]  enq_exc = '0;
   logic [NE-1:0][7:0]   enq_vstart = '0;
   logic [NW-1:0]        wb_valid = '0;
   logic [NW-1:0][8:0]   wb_ptr = '0;
   logic [NW-1:0][15:0]  wb_exc = '0;
   logic [NW-1:0][7:0]   wb_vstart = '0;
   logic                 redir_valid = 1'b0;
   logic [8:0]           redir_ptr = '0;
   logic                 redir_self = 1'b0;
   logic                 clear = 1'b0;
   logic                 hold_valid;
   logic [8:0]           hold_ptr;
   logic [15:0]          hold_exc;
   logic [7:0]           hold_vstart;

   always #(CLK_PERIOD / 2) clk = ~clk;

   oldest_exc_tracker dut_i (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_ptr(enq_ptr), .enq_exc(enq_exc), .enq_vstart(enq_vstart),
      .wb_valid(wb_valid), .wb_ptr(wb_ptr), .wb_exc(wb_exc), .wb_vstart(wb_vstart),
      .redir_valid(redir_valid), .redir_ptr(redir_ptr), .redir_self(redir_self),
      .clear(clear),
      .hold_valid(hold_valid), .hold_ptr(hold_ptr), .hold_exc(hold_exc),
      .hold_vstart(hold_vstart));

   int total = 0;
   int bad = 0;

   // Reference: every pending exception.
   bit         m_v   [64];
   logic [8:0] m_ptr [64];
   logic [7:0] m_vs  [64];
   logic [15:0] m_exc[64];

   function automatic logic [15:0] mk_exc(logic [8:0] p, logic [7:0] s);
      return {s, p[7:0]} ^ 16'h5A3C;
   endfunction

   function automatic bit ref_older(logic [8:0] a, logic [8:0] b);
      if (a[8] == b[8]) return a[7:0] < b[7:0];
      return a[7:0] > b[7:0];
   endfunction

   function automatic bit ref_gone(logic [8:0] c, logic [8:0] r, bit s);
      return ref_older(r, c) || (c == r && s);
   endfunction

   task automatic m_add(logic [8:0] p, logic [7:0] s);
      for (int i = 0; i < 64; i++) begin
         if (!m_v[i]) begin
            m_v[i] = 1'b1; m_ptr[i] = p; m_vs[i] = s; m_exc[i] = mk_exc(p, s);
            return;
         end
      end
   endtask

   task automatic m_clear();
      for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
   endtask

   task automatic m_kill(logic [8:0] r, bit s);
      for (int i = 0; i < 64; i++) if (m_v[i] && ref_gone(m_ptr[i], r, s)) m_v[i] = 1'b0;
   endtask

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_model(string req);
      int b;
      b = -1;
      for (int i = 0; i < 64; i++) begin
         if (m_v[i] && (b < 0 || ref_older(m_ptr[i], m_ptr[b]) ||
                        (m_ptr[i] == m_ptr[b] && m_vs[i] < m_vs[b]))) b = i;
      end
      chk(hold_valid == (b >= 0), req, "valid", 32'(hold_valid), 32'(b >= 0));
      if (b >= 0 && hold_valid) begin
         chk(hold_ptr == m_ptr[b] && hold_vstart == m_vs[b] && hold_exc == m_exc[b], req,
             "record", {7'd0, hold_ptr, hold_vstart, 8'd0}, {7'd0, m_ptr[b], m_vs[b], 8'd0});
      end
   endtask

   task automatic drive_idle();
      wb_valid = '0; enq_valid = '0; redir_valid = 1'b0; redir_self = 1'b0; clear = 1'b0;
   endtask

   task automatic apply(logic [5:0] wv, logic [5:0][8:0] wp, logic [5:0][7:0] ws,
                        logic [5:0] ev, logic [5:0][8:0] ep, logic [5:0][7:0] es,
                        bit clr, bit rv, logic [8:0] rp, bit rs, string req);
      @(negedge clk);
      wb_valid = wv; wb_ptr = wp; wb_vstart = ws;
      enq_valid = ev; enq_ptr = ep; enq_vstart = es;
      for (int i = 0; i < 6; i++) begin
         wb_exc[i]  = mk_exc(wp[i], ws[i]);
         enq_exc[i] = mk_exc(ep[i], es[i]);
      end
      clear = clr; redir_valid = rv; redir_ptr = rp; redir_self = rs;
      if (clr) m_clear();
      if (rv) m_kill(rp, rs);
      for (int i = 0; i < 6; i++)
         if (wv[i] && !(rv && ref_gone(wp[i], rp, rs))) m_add(wp[i], ws[i]);
      for (int i = 0; i < 6; i++) begin
         if (ev[i]) begin
            if (!(rv && ref_gone(ep[i], rp, rs))) m_add(ep[i], es[i]);
            break;
         end
      end
      @(posedge clk);
      @(negedge clk);
      drive_idle();
      @(posedge clk);
      @(negedge clk);
      check_model(req);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic [5:0][8:0] p0, p1;
      logic [5:0][7:0] s0, s1;
      m_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(hold_valid == 1'b0, "R1", "valid in reset", 32'(hold_valid), 0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(hold_valid == 1'b0, "R1", "valid after reset", 32'(hold_valid), 0);

      for (int v = 0; v < 15; v++) begin
         p0 = '0; s0 = '0; p1 = '0; s1 = '0;
         p0[VECS[v].wport] = VECS[v].wptr; s0[VECS[v].wport] = VECS[v].wvs;
         p1[VECS[v].eport] = VECS[v].eptr;
         apply(6'(VECS[v].wv) << VECS[v].wport, p0, s0,
               6'(VECS[v].ev) << VECS[v].eport, p1, s1,
               VECS[v].clr, VECS[v].rv, VECS[v].rptr, VECS[v].rs,
               $sformatf("R%0d", VECS[v].req));
      end

      // R2 and R3: every port busy; enqueue port 3 beats older port 5.
      p0 = '{9'h0B0, 9'h070, 9'h075, 9'h0A0, 9'h070, 9'h090};
      s0 = '{8'd0, 8'd2, 8'd0, 8'd0, 8'd5, 8'd0};
      p1 = '{9'h060, 9'h000, 9'h072, 9'h000, 9'h000, 9'h000};
      apply(6'h3F, p0, s0, 6'b101000, p1, '0, 1'b0, 1'b0, 9'h0, 1'b0, "R3");
      apply('0, '0, '0, '0, '0, '0, 1'b1, 1'b0, 9'h0, 1'b0, "R7");
      apply('0, '0, '0, 6'b101000, '{9'h060, 9'h0, 9'h072, 9'h0, 9'h0, 9'h0}, '0,
            1'b0, 1'b0, 9'h0, 1'b0, "R2");
      apply('0, '0, '0, '0, '0, '0, 1'b1, 1'b0, 9'h0, 1'b0, "R7");

      // R4: two edges from input to output.
      @(negedge clk);
      wb_valid = 6'b000001; wb_ptr[0] = 9'h0C0; wb_vstart[0] = 8'd0;
      wb_exc[0] = mk_exc(9'h0C0, 8'd0);
      @(posedge clk); @(negedge clk);
      drive_idle();
      chk(hold_valid == 1'b0, "R4", "valid after one edge", 32'(hold_valid), 0);
      @(posedge clk); @(negedge clk);
      chk(hold_valid && hold_ptr == 9'h0C0, "R4", "ptr after two edges", 32'(hold_ptr), 32'h0C0);

      // R7: clear while a younger candidate sits in stage one.
      wb_valid = 6'b000010; wb_ptr[1] = 9'h0D0; wb_vstart[1] = 8'd0;
      wb_exc[1] = mk_exc(9'h0D0, 8'd0);
      @(posedge clk); @(negedge clk);
      drive_idle(); clear = 1'b1;
      @(posedge clk); @(negedge clk);
      clear = 1'b0;
      chk(hold_valid && hold_ptr == 9'h0D0, "R7", "merge during clear", 32'(hold_ptr), 32'h0D0);

      // R9: redirect hits stage one, equal index without self survives.
      wb_valid = 6'b000100; wb_ptr[2] = 9'h0C8; wb_vstart[2] = 8'd0;
      wb_exc[2] = mk_exc(9'h0C8, 8'd0);
      @(posedge clk); @(negedge clk);
      drive_idle(); redir_valid = 1'b1; redir_ptr = 9'h0C8; redir_self = 1'b0;
      @(posedge clk); @(negedge clk);
      drive_idle();
      chk(hold_valid && hold_ptr == 9'h0C8, "R9", "stage kept", 32'(hold_ptr), 32'h0C8);

      // R9: redirect with self squashes stage one and the held record.
      wb_valid = 6'b010000; wb_ptr[4] = 9'h0C0; wb_vstart[4] = 8'd0;
      wb_exc[4] = mk_exc(9'h0C0, 8'd0);
      @(posedge clk); @(negedge clk);
      drive_idle(); redir_valid = 1'b1; redir_ptr = 9'h0C0; redir_self = 1'b1;
      @(posedge clk); @(negedge clk);
      drive_idle();
      @(posedge clk); @(negedge clk);
      chk(hold_valid == 1'b0, "R9", "stage squashed", 32'(hold_valid), 0);

      finish_run();
   end

endmodule